// File: doc/BRIEF.md
# Tagged-Word Producer/Consumer Memory

This block is a small word-addressed store in which every word carries one extra state bit that marks it as holding data (full) or free (empty). Producers and consumers use the bit to hand single words to each other without a separate lock. A synchronizing store goes through only on an empty word: it deposits the data and flips the word to full. A synchronizing load goes through only on a full word: it hands back the data and flips the word to empty. An access that finds the word in the wrong state is dropped, and the requester gets a retry answer so that it can issue the access again later. The state bit is tested and changed in the same cycle as the data access, so the test and the update cannot be split by another requester.

Several requesters each own one request port. One access is performed per cycle, and a fixed-priority arbiter picks it, with the lowest port index winning. A port that is not picked sees its ready low and keeps its request up. Plain loads and stores reach the data without testing or touching the state bit; they serve for setup and inspection. A count of the words that are currently full is available at all times.

Top module: `fe_sync_mem`

## Requirements
- R1: While reset is asserted and after it, every word is empty and zero, `full_count` is 0, and no port shows `req_ready`, `rsp_valid` or `rsp_retry`.
- R2: The operation code is 00 plain load, 01 plain store, 10 synchronizing load and 11 synchronizing store. A request is taken in the cycle when its `req_ready` is high, and exactly one cycle later that port alone shows `rsp_valid`. `rsp_rdata` is zero for stores and for retried accesses, and `rsp_retry` is never high without `rsp_valid`.
- R3: A synchronizing store to an empty word writes the data, marks the word full and answers without retry.
- R4: A synchronizing store to a full word answers with retry and leaves both the data and the state bit unchanged.
- R5: A synchronizing load from a full word returns the stored data, marks the word empty and answers without retry.
- R6: A synchronizing load from an empty word answers with retry and zero data and leaves the word empty.
- R7: A plain store writes the data, never retries and leaves the state bit unchanged.
- R8: A plain load returns the stored data, never retries and leaves the state bit unchanged.
- R9: When several ports request in one cycle, only the lowest-index requesting port gets `req_ready`. Ports that do not request never get it.
- R10: A port that lost arbitration and reissues its access sees the word state left by the winner.
- R11: `full_count` equals the number of full words and changes in the same cycle as the response that changed a state bit, by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NREQ | One request strobe per port |
| req_op | input | 2*NREQ | Operation code per port, port i in bits [2i+1:2i] |
| req_addr | input | AW*NREQ | Word address per port |
| req_wdata | input | DW*NREQ | Store data per port |
| req_ready | output | NREQ | Request of this port is taken this cycle |
| rsp_valid | output | NREQ | Response for the port taken in the previous cycle |
| rsp_retry | output | NREQ | Access was refused because of the word state |
| rsp_rdata | output | DW | Load data for the port showing rsp_valid |
| full_count | output | CW | Number of words currently full |

## Verification
The assertions assume that a requester drives its op, address and data stable whenever its strobe is up, and that the reset is held for at least one clock edge before the first request. The port-0 priority property also assumes that port 0 never withdraws a request after seeing ready; the bench changes every request only at the falling edge and decides each cycle afresh, so a withdrawn loser is legal and nothing is assumed about it. Random addresses are drawn from a narrow range so that collisions, refills of a full word and loads of an empty word happen often, while directed steps cover the fill-to-capacity and drain-to-zero ends of the count.

// File: rtl/fe_mem_pkg.sv
package fe_mem_pkg;

  typedef enum logic [1:0] {
    OP_PLAIN_RD = 2'b00,
    OP_PLAIN_WR = 2'b01,
    OP_SYNC_RD  = 2'b10,
    OP_SYNC_WR  = 2'b11
  } fe_op_e;

  // Synchronizing accesses test the state bit; plain ones ignore it.
  function automatic logic op_is_sync(fe_op_e op);
    return op[1];
  endfunction

  function automatic logic op_is_store(fe_op_e op);
    return op[0];
  endfunction

  // Whether the access may go through given the current word state.
  function automatic logic access_allowed(fe_op_e op, logic word_full);
    if (!op_is_sync(op)) return 1'b1;
    return op_is_store(op) ? !word_full : word_full;
  endfunction

endpackage

// File: rtl/fe_prio_arb.sv
module fe_prio_arb #(
  parameter int N = 2
) (
  input  logic [N-1:0] valid,
  output logic [N-1:0] grant,
  output logic         any_grant
);

  logic [N:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]     = valid[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | valid[i];
  end

  assign any_grant = blocked[N];

endmodule

// File: rtl/fe_tag_store.sv
module fe_tag_store
  import fe_mem_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic [AW-1:0]    acc_addr,
  input  fe_op_e           acc_op,
  output logic             acc_ok,
  output logic [DEPTH-1:0] tags,
  output logic [CW-1:0]    count
);

  logic [DEPTH-1:0] tag_q;
  logic [CW-1:0]    cnt_q;
  logic             cur_full;
  logic             set_full;
  logic             clr_full;

  assign cur_full = tag_q[acc_addr];
  assign acc_ok   = access_allowed(acc_op, cur_full);
  assign set_full = acc_en & acc_ok & (acc_op == OP_SYNC_WR);
  assign clr_full = acc_en & acc_ok & (acc_op == OP_SYNC_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      cnt_q <= '0;
    end else if (set_full) begin
      tag_q[acc_addr] <= 1'b1;
      cnt_q           <= cnt_q + 1'b1;
    end else if (clr_full) begin
      tag_q[acc_addr] <= 1'b0;
      cnt_q           <= cnt_q - 1'b1;
    end
  end

  assign tags  = tag_q;
  assign count = cnt_q;

endmodule

// File: rtl/fe_data_store.sv
module fe_data_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];

endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
  import fe_mem_pkg::*;
#(
  parameter int NREQ  = 2,
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREQ-1:0]    req_valid,
  input  logic [2*NREQ-1:0]  req_op,
  input  logic [AW*NREQ-1:0] req_addr,
  input  logic [DW*NREQ-1:0] req_wdata,
  output logic [NREQ-1:0]    req_ready,
  output logic [NREQ-1:0]    rsp_valid,
  output logic [NREQ-1:0]    rsp_retry,
  output logic [DW-1:0]      rsp_rdata,
  output logic [CW-1:0]      full_count
);

  // Named internal events, visible to the bound checker.
  logic [NREQ-1:0]  grant;
  logic             any_grant;
  fe_op_e           sel_op;
  logic [AW-1:0]    sel_addr;
  logic [DW-1:0]    sel_wdata;
  logic             acc_ok;
  logic             store_fire;
  logic             load_fire;
  logic [DW-1:0]    mem_rdata;
  logic [DW-1:0]    rdata_next;
  logic [DEPTH-1:0] tags_w;

  fe_prio_arb #(.N(NREQ)) u_arb (
    .valid     (req_valid),
    .grant     (grant),
    .any_grant (any_grant)
  );

  always_comb begin
    sel_op    = OP_PLAIN_RD;
    sel_addr  = '0;
    sel_wdata = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (grant[i]) begin
        sel_op    = fe_op_e'(req_op[2*i +: 2]);
        sel_addr  = req_addr[AW*i +: AW];
        sel_wdata = req_wdata[DW*i +: DW];
      end
    end
  end

  fe_tag_store #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (any_grant),
    .acc_addr (sel_addr),
    .acc_op   (sel_op),
    .acc_ok   (acc_ok),
    .tags     (tags_w),
    .count    (full_count)
  );

  assign store_fire = any_grant & acc_ok & op_is_store(sel_op);
  assign load_fire  = any_grant & acc_ok & ~op_is_store(sel_op);

  fe_data_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_data (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (store_fire),
    .addr  (sel_addr),
    .wdata (sel_wdata),
    .rdata (mem_rdata)
  );

  assign rdata_next = load_fire ? mem_rdata : '0;
  assign req_ready  = grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_retry <= '0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= grant;
      rsp_retry <= (any_grant & ~acc_ok) ? grant : '0;
      rsp_rdata <= rdata_next;
    end
  end

endmodule

// File: rtl/fe_sync_mem_chk.sv
module fe_sync_mem_chk #(
  parameter int NREQ  = 2,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NREQ-1:0]  req_valid,
  input logic [NREQ-1:0]  req_ready,
  input logic [NREQ-1:0]  rsp_valid,
  input logic [NREQ-1:0]  rsp_retry,
  input logic [CW-1:0]    full_count,
  input logic [DEPTH-1:0] tags_w
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (full_count == '0 && rsp_valid == '0 && rsp_retry == '0));

  p_ready_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  p_single_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  p_port0_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid[0] |-> req_ready[0]);

  p_rsp_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |=> ($countones(rsp_valid) == 1));

  p_rsp_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req_ready) |=> (rsp_valid == '0));

  p_retry_in_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_retry & ~rsp_valid) == '0);

  p_count_matches_r11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(full_count) == $countones(tags_w));

  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(full_count) <= DEPTH);

  p_count_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (full_count == $past(full_count)) ||
    (full_count == $past(full_count) + 1'b1) ||
    ($past(full_count) == full_count + 1'b1));

endmodule

bind fe_sync_mem fe_sync_mem_chk #(
  .NREQ  (NREQ),
  .DEPTH (DEPTH),
  .CW    (CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_retry  (rsp_retry),
  .full_count (full_count),
  .tags_w     (tags_w)
);

// File: tb/fe_sync_mem_test.sv
module fe_sync_mem_test;

  localparam int CLK_PERIOD = 10;
  localparam int NREQ  = 2;
  localparam int DEPTH = 16;
  localparam int DW    = 16;
  localparam int AW    = 4;
  localparam int CW    = 5;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NREQ-1:0]    req_valid = '0;
  logic [2*NREQ-1:0]  req_op = '0;
  logic [AW*NREQ-1:0] req_addr = '0;
  logic [DW*NREQ-1:0] req_wdata = '0;
  logic [NREQ-1:0]    req_ready;
  logic [NREQ-1:0]    rsp_valid;
  logic [NREQ-1:0]    rsp_retry;
  logic [DW-1:0]      rsp_rdata;
  logic [CW-1:0]      full_count;

  fe_sync_mem #(.NREQ(NREQ), .DEPTH(DEPTH), .DW(DW)) uut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_op (req_op), .req_addr (req_addr),
    .req_wdata (req_wdata), .req_ready (req_ready), .rsp_valid (rsp_valid),
    .rsp_retry (rsp_retry), .rsp_rdata (rsp_rdata), .full_count (full_count)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  logic [DW-1:0] m_data [DEPTH];
  bit            m_full [DEPTH];

  // Bench view of the rules: codes 10 load-sync, 11 store-sync.
  function automatic bit may_go(logic [1:0] op, bit full);
    case (op)
      2'b10:   return full;
      2'b11:   return !full;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int model_count();
    int n = 0;
    for (int i = 0; i < DEPTH; i++) if (m_full[i]) n++;
    return n;
  endfunction

  task automatic chk(bit cond, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit v0, logic [1:0] o0, logic [AW-1:0] a0, logic [DW-1:0] d0,
                      bit v1, logic [1:0] o1, logic [AW-1:0] a1, logic [DW-1:0] d1,
                      string req);
    logic [NREQ-1:0] eg;
    logic [1:0]      op;
    logic [AW-1:0]   ad;
    logic [DW-1:0]   wd;
    logic [DW-1:0]   erd;
    bit              ok;
    @(negedge clk);
    req_valid = {v1, v0};
    req_op    = {o1, o0};
    req_addr  = {a1, a0};
    req_wdata = {d1, d0};
    #1;
    eg = v0 ? 2'b01 : (v1 ? 2'b10 : 2'b00);
    chk(req_ready == eg, req, "ready", 32'(req_ready), 32'(eg));
    op = v0 ? o0 : o1;
    ad = v0 ? a0 : a1;
    wd = v0 ? d0 : d1;
    ok = 1'b1;
    erd = '0;
    if (eg != 0) begin
      ok = may_go(op, m_full[ad]);
      if (ok && !op[0]) erd = m_data[ad];
      if (ok && op[0]) m_data[ad] = wd;
      if (ok && op[1]) m_full[ad] = op[0];
    end
    @(posedge clk);
    #1;
    chk(rsp_valid == eg, req, "rsp_valid", 32'(rsp_valid), 32'(eg));
    chk(rsp_retry == (ok ? 2'b00 : eg), req, "rsp_retry", 32'(rsp_retry), 32'(ok ? 2'b00 : eg));
    chk(rsp_rdata == erd, req, "rsp_rdata", 32'(rsp_rdata), 32'(erd));
    chk(int'(full_count) == model_count(), req, "full_count", 32'(full_count), 32'(model_count()));
  endtask

  task automatic p0(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d, string req);
    step(1'b1, op, a, d, 1'b0, 2'b00, '0, '0, req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_data[i] = '0;
      m_full[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R1: state held in reset
    chk(full_count == 0, "R1", "count in reset", 32'(full_count), 0);
    chk(rsp_valid == 0 && rsp_retry == 0, "R1", "rsp in reset", 32'({rsp_valid, rsp_retry}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 0 && rsp_valid == 0, "R1", "idle after reset", 32'({req_ready, rsp_valid}), 0);

    p0(2'b10, 4'd2, 16'h0, "R6");       // load-sync of empty word: retry
    p0(2'b00, 4'd2, 16'h0, "R1");       // words start zero
    p0(2'b01, 4'd2, 16'hBEEF, "R7");    // plain store
    p0(2'b10, 4'd2, 16'h0, "R7");       // still empty after plain store
    p0(2'b00, 4'd2, 16'h0, "R8");       // plain load returns BEEF
    p0(2'b11, 4'd2, 16'h1234, "R3");    // store-sync into empty
    p0(2'b00, 4'd2, 16'h0, "R8");       // plain load keeps it full
    p0(2'b11, 4'd2, 16'h5555, "R4");    // store-sync into full: retry
    p0(2'b00, 4'd2, 16'h0, "R4");       // data unchanged 1234
    p0(2'b10, 4'd2, 16'h0, "R5");       // load-sync returns 1234
    p0(2'b10, 4'd2, 16'h0, "R5");       // now empty: retry

    // R9 collision, then R10 loser reissues
    step(1'b1, 2'b11, 4'd5, 16'hAAAA, 1'b1, 2'b11, 4'd5, 16'hBBBB, "R9");
    step(1'b0, 2'b00, 4'd0, 16'h0, 1'b1, 2'b11, 4'd5, 16'hBBBB, "R10");
    step(1'b0, 2'b00, 4'd0, 16'h0, 1'b1, 2'b10, 4'd5, 16'h0, "R10");
    step(1'b0, 2'b00, 4'd0, 16'h0, 1'b0, 2'b00, 4'd0, 16'h0, "R2");

    // R11 fill to capacity, then drain to zero
    for (int i = 0; i < DEPTH; i++) p0(2'b11, AW'(i), DW'(i * 3 + 1), "R11");
    chk(full_count == CW'(DEPTH), "R11", "count full", 32'(full_count), DEPTH);
    for (int i = 0; i < DEPTH; i++) p0(2'b10, AW'(i), 16'h0, "R11");
    chk(full_count == 0, "R11", "count drained", 32'(full_count), 0);

    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      step(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
           DW'($urandom),
           1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
           DW'($urandom), "R2");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule